// File: doc/BRIEF.md
# Strided Blit Descriptor Chain Builder

This block turns a two-dimensional copy request into a linked chain of DMA descriptors for a blit engine. A request names a system memory base, a frame buffer base, a line length in bytes, a line count, a memory stride and a signed frame buffer stride. The block first checks the request against a fixed set of legality rules. If the request is legal, it walks the lines and cuts each one wherever the system memory address crosses a 4 KiB page, then writes one four-word descriptor for each piece into a descriptor store.

Descriptors are written through a single-word write port, one word per clock, at consecutive 16-byte slots starting at a base address. The chain is linked back to front. The first descriptor written ends the chain, and each later one points at the descriptor written before it. When the walk is finished, the block pulses done and reports the descriptor count and the head address, which is the last slot written; the engine starts from that head. An illegal request instead gets a one-cycle error pulse with a reason code, and nothing is written. The system memory address is used directly as the bus address.

Top module: `blit_chain_builder`

## Requirements
- R1: Descriptor k occupies the four words at base + 16*k, where base is desc_base_i with bits [3:0] cleared. The words are, in address order: the system memory address at +0, the frame buffer address at +4, the byte size at +8 and the next pointer at +12. Exactly 4*N words are written for N descriptors.
- R2: Each segment is min(bytes left in the line, 4096 - mem[11:0]). No segment crosses a 4 KiB system memory page, and every size is between 1 and 4096.
- R3: The first descriptor's next pointer is 32'h0000_0002, where bit 1 is the end-of-chain flag. Descriptor k>0 points to base + 16*(k-1). On done, desc_cnt_o = N and head_o = base + 16*(N-1).
- R4: After each line, the memory address advances by mem_stride_i and the frame buffer address advances by fb_stride_i. The frame buffer stride is two's complement and may be negative. Within a line, both addresses advance by each segment size.
- R5: When mem_stride_i and fb_stride_i both equal line_len_i, the request is treated as one line of line_len_i*line_cnt_i bytes.
- R6: Reason codes on err_code_o are 1 zero, 2 size, 3 stride, 4 gap and 5 align, checked in that priority order. An illegal request writes no word and leaves desc_cnt_o = 0 and head_o = 0.
- R7: A request is rejected with code 1 if the line count or the line length is zero.
- R8: A request is rejected with code 2 if the line count after R5 exceeds 2048, or if line_cnt_i*mem_stride_i exceeds 16 MiB.
- R9: A request is rejected with code 3 if mem_stride_i < line_len_i or |fb_stride_i| < line_len_i. It is rejected with code 4 if mem_stride_i - line_len_i >= 4096.
- R10: A request is rejected with code 5 if mem_addr_i[3:0] != 0 or fb_addr_i[1:0] != 0. With more than one line after R5, it is also rejected with code 5 if mem_stride_i[3:0] != 0 or fb_stride_i[1:0] != 0.
- R11: Counting the edge that samples start_i as edge 1, err_o is high after edge 2, and done_o is high after edge 2+5N. Each is high for exactly one cycle.
- R12: After reset, busy_o, wr_en_o, done_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Accept a request (sampled while idle) |
| desc_base_i | input | 32 | Descriptor store base address |
| mem_addr_i | input | 32 | System memory start address |
| fb_addr_i | input | 32 | Frame buffer start address |
| line_len_i | input | 32 | Bytes per line |
| line_cnt_i | input | 16 | Number of lines |
| mem_stride_i | input | 32 | System memory line stride |
| fb_stride_i | input | 32 | Frame buffer line stride, signed |
| busy_o | output | 1 | Request in progress |
| wr_en_o | output | 1 | Descriptor word write strobe |
| wr_addr_o | output | 32 | Descriptor word address |
| wr_data_o | output | 32 | Descriptor word data |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle reject pulse |
| err_code_o | output | 3 | Reject reason |
| desc_cnt_o | output | 16 | Descriptors in the last chain |
| head_o | output | 32 | Chain head address |

## Verification
A rejected request resolves after two edges, counting the edge that samples start_i. A legal one takes one decision edge plus five edges per descriptor: one to size the segment and four word writes. The bench counts falling edges from the sampling edge up to the pulse and compares that count with 2 or 2+5N, where N is computed by its own segment walk. All results are sampled on falling edges. Descriptor words are captured on rising edges while the write strobe is high, and they are compared only after the done pulse, when every write is complete.

// File: rtl/blit_chain_pkg.sv
package blit_chain_pkg;
  typedef enum logic [2:0] {
    BE_NONE   = 3'd0,
    BE_ZERO   = 3'd1,
    BE_SIZE   = 3'd2,
    BE_STRIDE = 3'd3,
    BE_GAP    = 3'd4,
    BE_ALIGN  = 3'd5
  } blit_err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_GEN, ST_WRITE, ST_DONE
  } blit_state_e;

  localparam int unsigned WORDS_PER_DESC = 4;
  localparam logic [31:0] END_OF_CHAIN   = 32'h0000_0002;
endpackage

// File: rtl/blit_req_check.sv
module blit_req_check
  import blit_chain_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned CW        = 16,
  parameter int unsigned PAGE_W    = 12,
  parameter int unsigned MAX_LINES = 2048,
  parameter int unsigned MAX_BYTES = 32'h0100_0000
) (
  input  logic [AW-1:0] mem_addr_i,
  input  logic [AW-1:0] fb_addr_i,
  input  logic [AW-1:0] len_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] mstride_i,
  input  logic [AW-1:0] fstride_i,
  output blit_err_e     err_o,
  output logic [AW-1:0] eff_len_o,
  output logic [CW-1:0] eff_cnt_o
);
  localparam int unsigned PW = AW + CW;

  logic          collapse;
  logic [PW-1:0] prod;
  logic [AW-1:0] fs_mag;
  logic [AW-1:0] gap;
  logic          multi;

  always_comb begin
    collapse  = (mstride_i == len_i) && (fstride_i == len_i);
    prod      = PW'(cnt_i) * PW'(mstride_i);
    eff_len_o = collapse ? AW'(prod) : len_i;
    eff_cnt_o = collapse ? CW'(1) : cnt_i;
    fs_mag    = fstride_i[AW-1] ? (~fstride_i + AW'(1)) : fstride_i;
    gap       = mstride_i - len_i;
    multi     = eff_cnt_o > CW'(1);

    if (cnt_i == '0 || len_i == '0)
      err_o = BE_ZERO;
    else if (PW'(eff_cnt_o) > PW'(MAX_LINES) || prod > PW'(MAX_BYTES))
      err_o = BE_SIZE;
    else if (mstride_i < len_i || fs_mag < len_i)
      err_o = BE_STRIDE;
    else if (gap >= AW'(1 << PAGE_W))
      err_o = BE_GAP;
    else if (mem_addr_i[3:0] != 4'd0 || fb_addr_i[1:0] != 2'd0 ||
             (multi && (mstride_i[3:0] != 4'd0 || fstride_i[1:0] != 2'd0)))
      err_o = BE_ALIGN;
    else
      err_o = BE_NONE;
  end
endmodule

// File: rtl/blit_seg_calc.sv
module blit_seg_calc #(
  parameter int unsigned AW     = 32,
  parameter int unsigned PAGE_W = 12
) (
  input  logic [AW-1:0] cur_mem_i,
  input  logic [AW-1:0] rem_i,
  output logic [AW-1:0] seg_o
);
  logic [PAGE_W:0] room;

  always_comb begin
    room  = (PAGE_W+1)'(1 << PAGE_W) - {1'b0, cur_mem_i[PAGE_W-1:0]};
    seg_o = (rem_i < AW'(room)) ? rem_i : AW'(room);
  end
endmodule

// File: rtl/blit_chain_builder.sv
module blit_chain_builder
  import blit_chain_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned CW        = 16,
  parameter int unsigned DCW       = 16,
  parameter int unsigned PAGE_W    = 12,
  parameter int unsigned MAX_LINES = 2048,
  parameter int unsigned MAX_BYTES = 32'h0100_0000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [AW-1:0]  desc_base_i,
  input  logic [AW-1:0]  mem_addr_i,
  input  logic [AW-1:0]  fb_addr_i,
  input  logic [AW-1:0]  line_len_i,
  input  logic [CW-1:0]  line_cnt_i,
  input  logic [AW-1:0]  mem_stride_i,
  input  logic [AW-1:0]  fb_stride_i,
  output logic           busy_o,
  output logic           wr_en_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [AW-1:0]  wr_data_o,
  output logic           done_o,
  output logic           err_o,
  output logic [2:0]     err_code_o,
  output logic [DCW-1:0] desc_cnt_o,
  output logic [AW-1:0]  head_o
);
  localparam int unsigned WW = $clog2(WORDS_PER_DESC);

  blit_state_e   state_q;
  logic [AW-1:0] base_q, mem_q, fb_q, len_q, ms_q, fs_q;
  logic [CW-1:0] cnt_q, lines_q, line_idx_q;
  logic [AW-1:0] line_mem_q, line_fb_q, cur_mem_q, cur_fb_q, rem_q, seg_q;
  logic [AW-1:0] prev_ptr_q, head_q;
  logic [DCW-1:0] desc_idx_q, dcnt_q;
  logic [WW-1:0] word_q;
  logic          err_q;
  logic [2:0]    code_q;

  blit_err_e     chk_err;
  logic [AW-1:0] eff_len, seg, desc_addr;
  logic [CW-1:0] eff_cnt;

  blit_req_check #(
    .AW(AW), .CW(CW), .PAGE_W(PAGE_W), .MAX_LINES(MAX_LINES), .MAX_BYTES(MAX_BYTES)
  ) u_check (
    .mem_addr_i(mem_q), .fb_addr_i(fb_q), .len_i(len_q), .cnt_i(cnt_q),
    .mstride_i(ms_q), .fstride_i(fs_q),
    .err_o(chk_err), .eff_len_o(eff_len), .eff_cnt_o(eff_cnt)
  );

  blit_seg_calc #(.AW(AW), .PAGE_W(PAGE_W)) u_seg (
    .cur_mem_i(cur_mem_q), .rem_i(rem_q), .seg_o(seg)
  );

  assign desc_addr = base_q + AW'({desc_idx_q, 4'b0000});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      base_q     <= '0; mem_q <= '0; fb_q <= '0; len_q <= '0;
      ms_q       <= '0; fs_q <= '0; cnt_q <= '0; lines_q <= '0;
      line_idx_q <= '0; line_mem_q <= '0; line_fb_q <= '0;
      cur_mem_q  <= '0; cur_fb_q <= '0; rem_q <= '0; seg_q <= '0;
      prev_ptr_q <= END_OF_CHAIN; head_q <= '0;
      desc_idx_q <= '0; dcnt_q <= '0; word_q <= '0;
      err_q      <= 1'b0; code_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          base_q  <= {desc_base_i[AW-1:4], 4'b0000};
          mem_q   <= mem_addr_i;
          fb_q    <= fb_addr_i;
          len_q   <= line_len_i;
          cnt_q   <= line_cnt_i;
          ms_q    <= mem_stride_i;
          fs_q    <= fb_stride_i;
          err_q   <= 1'b0;
          code_q  <= '0;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (chk_err != BE_NONE) begin
            err_q   <= 1'b1;
            code_q  <= chk_err;
            dcnt_q  <= '0;
            head_q  <= '0;
            state_q <= ST_DONE;
          end else begin
            len_q      <= eff_len;
            lines_q    <= eff_cnt;
            line_mem_q <= mem_q;
            cur_mem_q  <= mem_q;
            line_fb_q  <= fb_q;
            cur_fb_q   <= fb_q;
            rem_q      <= eff_len;
            line_idx_q <= '0;
            desc_idx_q <= '0;
            prev_ptr_q <= END_OF_CHAIN;
            state_q    <= ST_GEN;
          end
        end
        ST_GEN: begin
          seg_q   <= seg;
          word_q  <= '0;
          state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          word_q <= word_q + 1'b1;
          if (word_q == WW'(WORDS_PER_DESC - 1)) begin
            prev_ptr_q <= desc_addr;
            desc_idx_q <= desc_idx_q + 1'b1;
            state_q    <= ST_GEN;
            if (rem_q == seg_q) begin
              // line finished: step to next line or close the chain
              if (line_idx_q == lines_q - 1'b1) begin
                head_q  <= desc_addr;
                dcnt_q  <= desc_idx_q + 1'b1;
                state_q <= ST_DONE;
              end else begin
                line_idx_q <= line_idx_q + 1'b1;
                line_mem_q <= line_mem_q + ms_q;
                line_fb_q  <= line_fb_q + fs_q;
                cur_mem_q  <= line_mem_q + ms_q;
                cur_fb_q   <= line_fb_q + fs_q;
                rem_q      <= len_q;
              end
            end else begin
              cur_mem_q <= cur_mem_q + seg_q;
              cur_fb_q  <= cur_fb_q + seg_q;
              rem_q     <= rem_q - seg_q;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (word_q)
      2'd0:    wr_data_o = cur_mem_q;
      2'd1:    wr_data_o = cur_fb_q;
      2'd2:    wr_data_o = seg_q;
      default: wr_data_o = prev_ptr_q;
    endcase
  end

  assign wr_en_o    = (state_q == ST_WRITE);
  assign wr_addr_o  = desc_addr + AW'({word_q, 2'b00});
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE) && !err_q;
  assign err_o      = (state_q == ST_DONE) && err_q;
  assign err_code_o = code_q;
  assign desc_cnt_o = dcnt_q;
  assign head_o     = head_q;
endmodule

// File: rtl/blit_chain_builder_chk.sv
module blit_chain_builder_chk #(
  parameter int unsigned AW  = 32,
  parameter int unsigned DCW = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           busy_o,
  input logic           wr_en_o,
  input logic [AW-1:0]  wr_addr_o,
  input logic [AW-1:0]  wr_data_o,
  input logic           done_o,
  input logic           err_o,
  input logic [2:0]     err_code_o,
  input logic [DCW-1:0] desc_cnt_o,
  input logic [AW-1:0]  head_o
);
  logic [11:0] last_off_q;
  logic        linked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_off_q <= '0;
      linked_q   <= 1'b0;
    end else begin
      if (wr_en_o && wr_addr_o[3:2] == 2'd0) last_off_q <= wr_data_o[11:0];
      if (!busy_o) linked_q <= 1'b0;
      else if (wr_en_o && wr_addr_o[3:2] == 2'd3) linked_q <= 1'b1;
    end
  end

  AST_WR_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);  // R1
  AST_WORD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o[3:2] != 2'd0) |-> ($past(wr_en_o) && wr_addr_o == $past(wr_addr_o) + 4));  // R1
  AST_SEG_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o[3:2] == 2'd2) |->
      (wr_data_o != '0 && wr_data_o <= 32'd4096 && ({21'b0, last_off_q} + {1'b0, wr_data_o}) <= 33'd4096));  // R2
  AST_CHAIN_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o[3:2] == 2'd3) |->
      (wr_data_o == (linked_q ? wr_addr_o - 28 : 32'h0000_0002)));  // R3
  AST_DONE_HAS_DESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (desc_cnt_o != '0 && head_o[3:0] == 4'd0));  // R3
  AST_ERR_CODED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_code_o >= 3'd1 && err_code_o <= 3'd5 && desc_cnt_o == '0));  // R6
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));  // R11
  AST_PULSE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |=> !(done_o || err_o));  // R11
endmodule

bind blit_chain_builder blit_chain_builder_chk #(.AW(AW), .DCW(DCW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .wr_en_o(wr_en_o),
  .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .done_o(done_o), .err_o(err_o),
  .err_code_o(err_code_o), .desc_cnt_o(desc_cnt_o), .head_o(head_o)
);

// File: tb/blit_chain_builder_tb_top.sv
module blit_chain_builder_tb_top;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam int CAP = 4096;
  localparam int LIMIT = 20000;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] mem_a = '0, fb_a = '0, len = '0, ms = '0, fs = '0;
  logic [15:0] cnt = '0;
  logic        busy, wr_en, done, err;
  logic [31:0] wr_addr, wr_data, head;
  logic [2:0]  code;
  logic [15:0] dcnt;

  int checks = 0, errors = 0, wr_count = 0, cycles = 0;
  logic [31:0] cap [0:CAP-1];
  logic [31:0] em [0:1023];
  logic [31:0] ef [0:1023];
  logic [31:0] es [0:1023];

  always #5 clk = ~clk;

  blit_chain_builder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .desc_base_i(BASE),
    .mem_addr_i(mem_a), .fb_addr_i(fb_a), .line_len_i(len), .line_cnt_i(cnt),
    .mem_stride_i(ms), .fb_stride_i(fs), .busy_o(busy), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .done_o(done), .err_o(err),
    .err_code_o(code), .desc_cnt_o(dcnt), .head_o(head)
  );

  always @(posedge clk) begin
    if (wr_en) begin
      wr_count <= wr_count + 1;
      if (((wr_addr - BASE) >> 2) < CAP) cap[(wr_addr - BASE) >> 2] <= wr_data;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // independent segment walk
  function automatic int model(input logic [31:0] m0, f0, l0, input logic [15:0] c0, input logic [31:0] s_m, s_f);
    logic [31:0] l, m, f, rem, room, s;
    int c, n;
    l = l0; c = int'(c0); n = 0;
    if (s_m == l0 && s_f == l0) begin l = l0 * 32'(c0); c = 1; end
    for (int ln = 0; ln < c; ln++) begin
      m = m0 + s_m * 32'(ln);
      f = f0 + s_f * 32'(ln);
      rem = l;
      while (rem != 0) begin
        room = 32'd4096 - {20'd0, m[11:0]};
        s = (rem < room) ? rem : room;
        em[n] = m; ef[n] = f; es[n] = s; n++;
        m += s; f += s; rem -= s;
      end
    end
    return n;
  endfunction

  task automatic issue(input logic [31:0] m, f, l, input logic [15:0] c, input logic [31:0] sm, sf);
    @(negedge clk);
    wr_count = 0;
    mem_a = m; fb_a = f; len = l; cnt = c; ms = sm; fs = sf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && !err && cycles < LIMIT) begin
      @(negedge clk);
      cycles++;
    end
    if (cycles >= LIMIT) chk("R11", "watchdog expired", 32'(cycles), 32'(LIMIT - 1));
  endtask

  task automatic run_ok(input string tag, input logic [31:0] m, f, l, input logic [15:0] c, input logic [31:0] sm, sf);
    int n;
    n = model(m, f, l, c, sm, sf);
    issue(m, f, l, c, sm, sf);
    chk("R11", {tag, " done seen"}, {31'd0, done}, 32'd1);
    chk("R11", {tag, " done latency"}, 32'(cycles), 32'(2 + 5 * n));
    chk("R3", {tag, " desc count"}, {16'd0, dcnt}, 32'(n));
    chk("R3", {tag, " head"}, head, BASE + 32'(16 * (n - 1)));
    chk("R1", {tag, " word count"}, 32'(wr_count), 32'(4 * n));
    for (int k = 0; k < n; k++) begin
      chk(tag, "mem addr", cap[4*k], em[k]);
      chk(tag, "fb addr", cap[4*k+1], ef[k]);
      chk(tag, "size", cap[4*k+2], es[k]);
      chk("R3", "next ptr", cap[4*k+3], (k == 0) ? 32'h2 : BASE + 32'(16 * (k - 1)));
    end
    @(negedge clk);
    chk("R11", {tag, " done one cycle"}, {31'd0, done}, 32'd0);
  endtask

  task automatic run_err(input string tag, input logic [31:0] m, f, l, input logic [15:0] c, input logic [31:0] sm, sf, input logic [2:0] exp_code);
    issue(m, f, l, c, sm, sf);
    chk("R11", {tag, " err seen"}, {31'd0, err}, 32'd1);
    chk("R11", {tag, " err latency"}, 32'(cycles), 32'd2);
    chk(tag, "reason code", {29'd0, code}, {29'd0, exp_code});
    chk("R6", {tag, " no writes"}, 32'(wr_count), 32'd0);
    chk("R6", {tag, " count cleared"}, {16'd0, dcnt}, 32'd0);
    chk("R6", {tag, " head cleared"}, head, 32'd0);
    @(negedge clk);
    chk("R11", {tag, " err one cycle"}, {31'd0, err}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R12", "busy after reset", {31'd0, busy}, 32'd0);
    chk("R12", "wr_en after reset", {31'd0, wr_en}, 32'd0);
    chk("R12", "done after reset", {31'd0, done}, 32'd0);
    chk("R12", "err after reset", {31'd0, err}, 32'd0);
  endtask

  initial begin
    #23 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R4 multi-line, no page crossing
    run_ok("R4", 32'h3000_0000, 32'h0000_0400, 32'h40, 16'd4, 32'h80, 32'h100);
    // R2 page split inside a line
    run_ok("R2", 32'h4000_0F00, 32'h0000_8000, 32'h300, 16'd2, 32'h400, 32'h300);
    // R5 collapse into one long line
    run_ok("R5", 32'h5000_0400, 32'h0002_0000, 32'h800, 16'd3, 32'h800, 32'h800);
    // R4 negative frame buffer stride
    run_ok("R4", 32'h6000_0000, 32'h0001_0000, 32'h40, 16'd3, 32'h80, 32'hFFFF_FFC0);
    // R10 single line ignores stride alignment
    run_ok("R10", 32'h7000_0FF0, 32'h0000_0100, 32'h20, 16'd1, 32'h24, 32'h22);
    // R1 long line split across three pages
    run_ok("R1", 32'h8000_0800, 32'h0000_0000, 32'h2000, 16'd1, 32'h2000, 32'h3000);
    run_err("R7", 32'h3000_0000, 32'h0, 32'h0, 16'd4, 32'h80, 32'h80, 3'd1);
    run_err("R7", 32'h3000_0000, 32'h0, 32'h40, 16'd0, 32'h80, 32'h80, 3'd1);
    run_err("R8", 32'h3000_0000, 32'h0, 32'h10, 16'd2049, 32'h20, 32'h20, 3'd2);
    run_err("R8", 32'h3000_0000, 32'h0, 32'h1100, 16'd2048, 32'h2010, 32'h2010, 3'd2);
    run_err("R9", 32'h3000_0000, 32'h0, 32'h80, 16'd2, 32'h40, 32'h80, 3'd3);
    run_err("R9", 32'h3000_0000, 32'h0, 32'h80, 16'd2, 32'h80, 32'hFFFF_FFC0, 3'd3);
    run_err("R9", 32'h3000_0000, 32'h0, 32'h10, 16'd2, 32'h1010, 32'h10, 3'd4);
    run_err("R10", 32'h3000_0008, 32'h0, 32'h40, 16'd2, 32'h80, 32'h80, 3'd5);
    run_err("R10", 32'h3000_0000, 32'h2, 32'h40, 16'd2, 32'h80, 32'h80, 3'd5);
    run_err("R10", 32'h3000_0000, 32'h0, 32'h40, 16'd2, 32'h88, 32'h80, 3'd5);
    // R6 priority: zero length beats misalignment
    run_err("R6", 32'h3000_0008, 32'h1, 32'h0, 16'd2, 32'h88, 32'h80, 3'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule